// File: doc/BRIEF.md
# Masked Interrupt Request Controller

This block gathers up to eight interrupt sources into a pending register and drives one level-sensitive interrupt line toward a host. A source sets its pending bit with a one-cycle post pulse. The bit is cleared by an external clear pulse or by the host through an acknowledge write. An enable mask selects which pending bits can hold the line high. The host stores the mask in inverted form: a written one disables its source. The line has no priority, in-service or vectoring logic. It is high for exactly as long as some pending bit is also enabled.

The host reaches the block over a small register port. Each cycle with `bus_valid` high is one access. The port never back-pressures, so a request is always taken in the cycle it is presented. A read returns its data one cycle later, marked by `rd_valid`. The port also decodes a second controller bank. That bank keeps a mask value and answers reads, but it has no pending bits and never affects the interrupt line.

Register map (3-bit address): 0 = bank A mask, 1 = bank A status, 2 = bank A acknowledge, 4 = bank B mask, 5 = bank B status, 6 = bank B acknowledge, 3 and 7 unused.

Top module: `irq_ctrl`

## Requirements
- R1: A write to address 0 stores the bitwise inverse of the data as the enable mask. A read of address 0 returns the inverse of the enable mask, which is the last value written.
- R2: Each bit set in `post_vec` sets that pending bit, and each bit set in `clear_vec` clears it. When both name the same bit in one cycle, the bit ends cleared.
- R3: A write to address 2 with data bits [3:0] = n clears pending bit n when n < 8 and leaves every other bit unchanged. Codes 8 to 15 change nothing. If a post hits the same bit in that cycle, the bit ends cleared.
- R4: `irq` is high in the cycle after any update that leaves (pending AND enable) nonzero, and low in the cycle after any update that makes it zero.
- R5: A read of address 1 returns the raw pending register, whatever the mask holds.
- R6: A read of address 5 returns 0x00. A write to address 4 is stored, and a read of address 4 returns its bitwise inverse. Writes to addresses 4 and 6 change neither the pending register nor `irq`.
- R7: After reset the pending register is 0x00, the enable mask is 0x00 (address 0 reads 0xFF), the bank B mask is 0x00 (address 4 reads 0xFF), and `irq` is low.
- R8: A read issued in cycle n gives `rd_valid` high and its data in cycle n+1. `rd_valid` is low in every other cycle. Reads of addresses 2, 3, 6 and 7 return 0x00. Writes to addresses 3 and 7 change no state.
- R9: A read of address 1 issued in the same cycle as a post, clear or acknowledge returns the pending value from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 8 | Read data |
| post_vec | input | 8 | One-cycle pulses that set pending bits |
| clear_vec | input | 8 | One-cycle pulses that clear pending bits |
| irq | output | 1 | Level interrupt to the host |

## Verification
Every cycle, the assertions check that posted bits appear and cleared bits are gone. They also check that an in-range acknowledge empties its bit, that a mask write lands inverted, and that bank B acknowledges leave the pending register untouched. They further check that `irq` rises only after a post or a bank A mask write, and that `rd_valid` follows read requests by one cycle. The bench scenarios cover the rest. Those are mask and status read-back values, out-of-range acknowledge codes, the zero reads of bank B and unused addresses, and a status read racing an update that returns the older value. They also compare the full interrupt level against an arithmetic model after each access.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A_MASK = 3'd0,
    SEL_A_STAT = 3'd1,
    SEL_A_ACK  = 3'd2,
    SEL_RSV3   = 3'd3,
    SEL_B_MASK = 3'd4,
    SEL_B_STAT = 3'd5,
    SEL_B_ACK  = 3'd6,
    SEL_RSV7   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
  import irq_ctrl_pkg::*;
(
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_mask_a,
  output logic              wr_ack_a,
  output logic              wr_mask_b,
  output logic              rd_req
);
  reg_sel_e sel;
  logic     wr_any;

  always_comb begin
    sel       = reg_sel_e'(bus_addr);
    wr_any    = bus_valid && bus_write;
    wr_mask_a = wr_any && (sel == SEL_A_MASK);
    wr_ack_a  = wr_any && (sel == SEL_A_ACK);
    wr_mask_b = wr_any && (sel == SEL_B_MASK);
    rd_req    = bus_valid && !bus_write;
  end
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int SRC_W = 8,
  localparam int IDX_W = $clog2(SRC_W),
  localparam int ACK_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] post_vec,
  input  logic [SRC_W-1:0] clear_vec,
  input  logic             ack_stb,
  input  logic [ACK_W-1:0] ack_code,
  output logic [SRC_W-1:0] pend_q
);
  logic [SRC_W-1:0] ack_hit;
  logic [SRC_W-1:0] pend_d;

  for (genvar i = 0; i < SRC_W; i++) begin : g_ack
    assign ack_hit[i] = ack_stb && (ack_code == ACK_W'(i));
  end

  // clearing of any kind takes precedence over a post in the same cycle
  assign pend_d = (pend_q | post_vec) & ~clear_vec & ~ack_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_mask_a,
  input  logic             wr_mask_b,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] en_q,
  output logic [SRC_W-1:0] mask_b_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      mask_b_q <= '0;
    end else begin
      if (wr_mask_a) en_q     <= ~wdata;
      if (wr_mask_b) mask_b_q <= wdata;
    end
  end
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_ctrl_pkg::*;
#(
  parameter int SRC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SRC_W-1:0]  pend_q,
  input  logic [SRC_W-1:0]  en_q,
  input  logic [SRC_W-1:0]  mask_b_q,
  output logic              rd_valid,
  output logic [SRC_W-1:0]  rd_data
);
  logic [SRC_W-1:0] mux;

  always_comb begin
    unique case (reg_sel_e'(rd_addr))
      SEL_A_MASK: mux = ~en_q;
      SEL_A_STAT: mux = pend_q;
      SEL_B_MASK: mux = ~mask_b_q;
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= mux;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int SRC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [SRC_W-1:0]  bus_wdata,
  output logic              rd_valid,
  output logic [SRC_W-1:0]  rd_data,
  input  logic [SRC_W-1:0]  post_vec,
  input  logic [SRC_W-1:0]  clear_vec,
  output logic              irq
);
  localparam int IDX_W = $clog2(SRC_W);
  localparam int ACK_W = IDX_W + 1;

  logic             wr_mask_a, wr_ack_a, wr_mask_b, rd_req;
  logic [SRC_W-1:0] pend_q, en_q, mask_b_q;

  irq_bus_dec u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .wr_mask_a (wr_mask_a),
    .wr_ack_a  (wr_ack_a),
    .wr_mask_b (wr_mask_b),
    .rd_req    (rd_req)
  );

  irq_pending_reg #(.SRC_W(SRC_W)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .post_vec  (post_vec),
    .clear_vec (clear_vec),
    .ack_stb   (wr_ack_a),
    .ack_code  (bus_wdata[ACK_W-1:0]),
    .pend_q    (pend_q)
  );

  irq_mask_regs #(.SRC_W(SRC_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask_a (wr_mask_a),
    .wr_mask_b (wr_mask_b),
    .wdata     (bus_wdata),
    .en_q      (en_q),
    .mask_b_q  (mask_b_q)
  );

  irq_read_port #(.SRC_W(SRC_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_addr  (bus_addr),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .mask_b_q (mask_b_q),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign irq = |(pend_q & en_q);
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int SRC_W = 8,
  localparam int IDX_W = $clog2(SRC_W),
  localparam int ACK_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [SRC_W-1:0]  bus_wdata,
  input logic              rd_valid,
  input logic [SRC_W-1:0]  post_vec,
  input logic [SRC_W-1:0]  clear_vec,
  input logic              irq,
  input logic [SRC_W-1:0]  pend_q,
  input logic [SRC_W-1:0]  en_q
);
  logic wr_a_mask, wr_a_ack, wr_b_ack, rd;
  assign wr_a_mask = bus_valid && bus_write && (bus_addr == SEL_A_MASK);
  assign wr_a_ack  = bus_valid && bus_write && (bus_addr == SEL_A_ACK);
  assign wr_b_ack  = bus_valid && bus_write && (bus_addr == SEL_B_ACK);
  assign rd        = bus_valid && !bus_write;

  p_post_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_vec == '0 && !wr_a_ack) |=> ((pend_q & $past(post_vec)) == $past(post_vec)));

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clear_vec)) == '0));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_ack && (bus_wdata[ACK_W-1:0] < ACK_W'(SRC_W)))
      |=> !pend_q[$past(bus_wdata[IDX_W-1:0])]);

  p_mask_inverted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a_mask |=> (en_q == ~$past(bus_wdata)));

  p_irq_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(post_vec) != '0 || $past(wr_a_mask)));

  p_bank_b_ack_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b_ack && post_vec == '0 && clear_vec == '0) |=> $stable(pend_q));

  p_rd_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid == $past(rd)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .post_vec  (post_vec),
  .clear_vec (clear_vec),
  .irq       (irq),
  .pend_q    (pend_q),
  .en_q      (en_q)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, post_vec = '0, clear_vec = '0;
  logic       rd_valid, irq;
  logic [7:0] rd_data;

  int vectors = 0, errors = 0;
  logic [7:0] m_pend = '0, m_en = '0, m_mb = '0;

  always #4 clk = ~clk;  // 125 MHz

  irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .post_vec(post_vec), .clear_vec(clear_vec), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one bus/source cycle; inputs change on the falling edge, results sampled on the next
  task automatic step(input logic v, input logic w, input logic [2:0] a,
                      input logic [7:0] d, input logic [7:0] p, input logic [7:0] c,
                      input string req);
    logic [7:0] exp_rd;
    logic [7:0] ackm;
    case (a)
      3'd0: exp_rd = ~m_en;
      3'd1: exp_rd = m_pend;      // value before this cycle's update (R9)
      3'd4: exp_rd = ~m_mb;
      default: exp_rd = 8'h00;
    endcase
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    post_vec = p; clear_vec = c;
    @(negedge clk);
    ackm = 8'h00;
    if (v && w) begin
      if (a == 3'd0) m_en = ~d;
      if (a == 3'd4) m_mb = d;
      if (a == 3'd2 && d[3] == 1'b0) ackm = 8'(1) << d[2:0];
    end
    m_pend = (m_pend | p) & ~c & ~ackm;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    post_vec = '0; clear_vec = '0;
    check({req, "/R8 rd_valid"}, {7'd0, rd_valid}, {7'd0, v && !w});
    if (v && !w) check(req, rd_data, exp_rd);
    check({req, "/R4 irq"}, {7'd0, irq}, {7'd0, |(m_pend & m_en)});
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    step(1'b1, 1'b0, a, 8'h00, 8'h00, 8'h00, req);
  endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string req);
    step(1'b1, 1'b1, a, d, 8'h00, 8'h00, req);
  endtask
  task automatic src(input logic [7:0] p, input logic [7:0] c, input string req);
    step(1'b0, 1'b0, 3'd0, 8'h00, p, c, req);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 irq", {7'd0, irq}, 8'h00);
    rd(3'd0, "R7 mask A");
    rd(3'd1, "R7 status");
    rd(3'd4, "R7 mask B");

    // R1/R4/R5: mask sweep with all sources pending
    src(8'hFF, 8'h00, "R2 post all");
    for (int m = 0; m < 256; m++) begin
      wr(3'd0, 8'(m), "R1 mask write");
      rd(3'd0, "R1 mask readback");
      rd(3'd1, "R5 status unmasked");
    end

    // R3: every acknowledge code
    wr(3'd0, 8'h00, "R1 enable all");
    for (int k = 0; k < 16; k++) begin
      src(8'hFF, 8'h00, "R2 refill");
      wr(3'd2, 8'(k), "R3 ack");
      rd(3'd1, "R3 status after ack");
    end
    // R3: ack racing a post on the same bit
    step(1'b1, 1'b1, 3'd2, 8'h05, 8'h20, 8'h00, "R3 ack vs post");
    rd(3'd1, "R3 ack wins");

    // R2/R4: post/clear sweep, including collisions
    for (int p = 0; p < 256; p++) begin
      logic [7:0] c;
      c = {8'(p)} ^ 8'h5A;
      c = {c[2:0], c[7:3]};
      src(8'(p), c, "R2 post/clear");
      rd(3'd1, "R2 status");
      if (p % 32 == 0) wr(3'd0, 8'(p) ^ 8'hC3, "R4 remask");
    end
    src(8'hFF, 8'hFF, "R2 full collision");
    rd(3'd1, "R2 clear wins");

    // R6: bank B
    wr(3'd0, 8'h00, "R1 enable all");
    src(8'h81, 8'h00, "R2 post");
    for (int m = 0; m < 256; m++) begin
      wr(3'd4, 8'(m), "R6 mask B write");
      rd(3'd4, "R6 mask B readback");
    end
    for (int k = 0; k < 16; k++) wr(3'd6, 8'(k), "R6 ack B");
    rd(3'd1, "R6 status A untouched");
    rd(3'd5, "R6 status B zero");
    rd(3'd0, "R6 mask A untouched");

    // R8: unused and write-only addresses
    wr(3'd3, 8'hFF, "R8 write rsv3");
    wr(3'd7, 8'hFF, "R8 write rsv7");
    rd(3'd3, "R8 read rsv3");
    rd(3'd7, "R8 read rsv7");
    rd(3'd2, "R8 read ack A");
    rd(3'd6, "R8 read ack B");
    rd(3'd1, "R8 status after rsv writes");
    rd(3'd0, "R8 mask after rsv writes");

    // R9: status read racing updates
    step(1'b1, 1'b0, 3'd1, 8'h00, 8'h3C, 8'h00, "R9 read vs post");
    step(1'b1, 1'b0, 3'd1, 8'h00, 8'h00, 8'h0F, "R9 read vs clear");
    rd(3'd1, "R9 settled");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule